// File: doc/BRIEF.md
# RoCE v2 Transmit Packet Framer

This block turns one RDMA transfer into one routable RoCE v2 packet on a byte-wide output stream. A sender presents a header descriptor (link-layer and network addresses, transport opcode, destination queue pair, packet sequence number and, for remote memory operations, the remote virtual address, remote key and DMA length) together with the payload length. The framer then streams out the Ethernet, IPv4 and UDP headers, the base transport header, the remote-memory extension header when the opcode needs it, the payload bytes taken from an input stream, zero pad bytes up to a 4-byte boundary, and a 4-byte invariant CRC trailer.

All length fields and the IPv4 header checksum are derived from the latched descriptor before the first byte leaves. The invariant CRC runs alongside the output, byte by byte, with the fields that routers may rewrite forced to ones. The frame check sequence is left to the MAC that follows. Both streams use valid/ready: a byte moves only in a cycle where both are high. While the framer drives header, pad or trailer bytes it holds the byte and valid steady under back-pressure. During the payload it passes the input through combinationally, so input ready follows output ready and output valid follows input valid. It accepts a new descriptor only when the previous packet's last byte has gone.

Top module: `rv2_framer`

## Requirements
- R1: Bytes leave in the order Ethernet (destination MAC, source MAC, type 0x0800), IPv4 (0x45, 0x00, total length, 0x0000, 0x40, 0x00, TTL 64, protocol 17, checksum, source IP, destination IP), UDP (8 bytes), base transport header (opcode, flags byte, partition key 0xFFFF, 0x00, 24-bit destination QP, 0x00, 24-bit PSN). Every multi-byte field goes out most significant byte first.
- R2: The UDP header is source port 0xC000, destination port 4791 (0x12B7), length, and a checksum of 0x0000.
- R3: When the low five opcode bits equal 0x06, 0x0A or 0x0C, a 16-byte extension header follows the base transport header: 64-bit virtual address, 32-bit remote key, 32-bit DMA length. Other opcodes leave it out.
- R4: With pay_len bytes of payload, pad = (4 - pay_len mod 4) mod 4 zero bytes follow the payload. The transport flags byte (header byte 43) carries pad in bits 5:4 and is zero elsewhere.
- R5: IPv4 total length = 20 + UDP length. UDP length = 8 + 12 + (16 if extension) + pay_len + pad + 4.
- R6: The IPv4 checksum (bytes 24 and 25) is the ones-complement of the ones-complement sum of the ten header words taken with the checksum at zero.
- R7: The trailer is the reflected CRC-32 (polynomial 0xEDB88320, initial all ones, final inversion), least significant byte first. It runs over eight 0xFF bytes and then every byte from the IPv4 header to the last pad byte, with bytes 15, 22, 24, 25, 40, 41 and 46 (type of service, TTL, IP checksum, UDP checksum, transport reserved byte) taken as 0xFF.
- R8: While m_tvalid is high and m_tready is low outside the payload, m_tvalid and m_tdata stay unchanged in the next cycle.
- R9: s_tready is high only in the payload phase, where it equals m_tready, and each accepted input byte is the output byte of that cycle.
- R10: hdr_ready is high only while idle. After a descriptor is accepted it stays low until the packet's last byte has been accepted.
- R11: m_tlast marks only the last trailer byte. A packet is pay_len + pad + 58 bytes long, or + 74 with the extension.
- R12: During and right after reset, m_tvalid and s_tready are low and hdr_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Descriptor valid |
| hdr_ready | output | 1 | Descriptor accepted when high with hdr_valid |
| dst_mac | input | 48 | Destination MAC address |
| src_mac | input | 48 | Source MAC address |
| src_ip | input | 32 | Source IPv4 address |
| dst_ip | input | 32 | Destination IPv4 address |
| opcode | input | 8 | Transport opcode |
| dest_qp | input | 24 | Destination queue pair |
| psn | input | 24 | Packet sequence number |
| vaddr | input | 64 | Remote virtual address (extension header) |
| rkey | input | 32 | Remote key (extension header) |
| dma_len | input | 32 | DMA length (extension header) |
| pay_len | input | 16 | Payload bytes to take from the input stream |
| s_tvalid | input | 1 | Payload byte valid |
| s_tready | output | 1 | Payload byte accepted |
| s_tdata | input | 8 | Payload byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tready | input | 1 | Output byte accepted |
| m_tdata | output | 8 | Output byte |
| m_tlast | output | 1 | Last byte of packet |

## Verification
The hardest case to reach is back-pressure at the edges between phases. A stall on the last header byte, on a pad byte or between trailer bytes must neither corrupt the CRC nor skip a byte. Meanwhile payload bubbles coming from the source side must not be taken for stalls. The stimulus drives independent pseudo-random patterns on m_tready and s_tvalid across packets with every pad count (0 to 3), with and without the extension header, with an empty payload and with a 2049-byte payload. Each output byte is compared against a packet built and CRC-checked separately in the bench.

// File: rtl/rv2_pkg.sv
`timescale 1ns/1ps
package rv2_pkg;
  localparam int ETH_BYTES  = 14;
  localparam int IP_BYTES   = 20;
  localparam int UDP_BYTES  = 8;
  localparam int BTH_BYTES  = 12;
  localparam int RETH_BYTES = 16;
  localparam int ICRC_BYTES = 4;
  localparam int PLEN_W     = 16;
  localparam int IP_OFF     = ETH_BYTES;
  localparam int UDP_OFF    = IP_OFF + IP_BYTES;
  localparam int BTH_OFF    = UDP_OFF + UDP_BYTES;
  localparam int RETH_OFF   = BTH_OFF + BTH_BYTES;
  localparam int HDR_BASE   = RETH_OFF;
  localparam int HDR_MAX    = HDR_BASE + RETH_BYTES;
  localparam int PREFIX_ONES = 8;
  localparam logic [15:0] ROCE_PORT = 16'd4791;
  localparam logic [31:0] CRC_POLY  = 32'hEDB88320;

  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_PAY, ST_PAD, ST_TRL} rv2_state_e;

  typedef struct packed {
    logic [47:0] dst_mac;
    logic [47:0] src_mac;
    logic [31:0] src_ip;
    logic [31:0] dst_ip;
    logic [7:0]  opcode;
    logic [23:0] dest_qp;
    logic [23:0] psn;
    logic [63:0] vaddr;
    logic [31:0] rkey;
    logic [31:0] dma_len;
    logic [PLEN_W-1:0] pay_len;
  } rv2_desc_t;

  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  function automatic logic has_reth(input logic [7:0] op);
    case (op[4:0])
      5'h06, 5'h0A, 5'h0C: return 1'b1;
      default:             return 1'b0;
    endcase
  endfunction

  function automatic logic icrc_mask(input logic [6:0] i);
    return (i == 7'(IP_OFF + 1))  || (i == 7'(IP_OFF + 8))  ||
           (i == 7'(IP_OFF + 10)) || (i == 7'(IP_OFF + 11)) ||
           (i == 7'(UDP_OFF + 6)) || (i == 7'(UDP_OFF + 7)) ||
           (i == 7'(BTH_OFF + 4));
  endfunction
endpackage

// File: rtl/rv2_hdr_build.sv
`timescale 1ns/1ps
module rv2_hdr_build
  import rv2_pkg::*;
#(
  parameter logic [15:0] SRC_PORT = 16'hC000,
  parameter logic [15:0] PKEY     = 16'hFFFF,
  parameter logic [7:0]  TTL      = 8'd64
) (
  input  rv2_desc_t               desc,
  output logic [HDR_MAX*8-1:0]    hdr_vec,
  output logic [6:0]              hdr_len,
  output logic [1:0]              pad_cnt
);
  logic        reth;
  logic [15:0] padded, bth_len, udp_len, ip_len, cks;
  logic [19:0] sum;
  logic [16:0] fold1;
  logic [15:0] fold2;
  logic [7:0]  hb [HDR_MAX];

  always_comb begin
    reth    = has_reth(desc.opcode);
    pad_cnt = 2'd0 - desc.pay_len[1:0];
    padded  = desc.pay_len + {14'd0, pad_cnt};
    bth_len = padded + 16'(BTH_BYTES + ICRC_BYTES) + (reth ? 16'(RETH_BYTES) : 16'd0);
    udp_len = bth_len + 16'(UDP_BYTES);
    ip_len  = udp_len + 16'(IP_BYTES);
    hdr_len = reth ? 7'(HDR_MAX) : 7'(HDR_BASE);

    // ones-complement sum of the IPv4 header words, checksum word taken as zero
    sum = 20'h04500 + {4'h0, ip_len} + 20'h04000 + {4'h0, TTL, 8'h11}
        + {4'h0, desc.src_ip[31:16]} + {4'h0, desc.src_ip[15:0]}
        + {4'h0, desc.dst_ip[31:16]} + {4'h0, desc.dst_ip[15:0]};
    fold1 = {1'b0, sum[15:0]} + {13'd0, sum[19:16]};
    fold2 = fold1[15:0] + {15'd0, fold1[16]};
    cks   = ~fold2;

    for (int k = 0; k < 6; k++) begin
      hb[k]     = desc.dst_mac[8*(5-k) +: 8];
      hb[6 + k] = desc.src_mac[8*(5-k) +: 8];
    end
    hb[12] = 8'h08;
    hb[13] = 8'h00;
    hb[IP_OFF + 0]  = 8'h45;
    hb[IP_OFF + 1]  = 8'h00;
    hb[IP_OFF + 2]  = ip_len[15:8];
    hb[IP_OFF + 3]  = ip_len[7:0];
    hb[IP_OFF + 4]  = 8'h00;
    hb[IP_OFF + 5]  = 8'h00;
    hb[IP_OFF + 6]  = 8'h40;
    hb[IP_OFF + 7]  = 8'h00;
    hb[IP_OFF + 8]  = TTL;
    hb[IP_OFF + 9]  = 8'h11;
    hb[IP_OFF + 10] = cks[15:8];
    hb[IP_OFF + 11] = cks[7:0];
    for (int k = 0; k < 4; k++) begin
      hb[IP_OFF + 12 + k] = desc.src_ip[8*(3-k) +: 8];
      hb[IP_OFF + 16 + k] = desc.dst_ip[8*(3-k) +: 8];
    end
    hb[UDP_OFF + 0] = SRC_PORT[15:8];
    hb[UDP_OFF + 1] = SRC_PORT[7:0];
    hb[UDP_OFF + 2] = ROCE_PORT[15:8];
    hb[UDP_OFF + 3] = ROCE_PORT[7:0];
    hb[UDP_OFF + 4] = udp_len[15:8];
    hb[UDP_OFF + 5] = udp_len[7:0];
    hb[UDP_OFF + 6] = 8'h00;
    hb[UDP_OFF + 7] = 8'h00;
    hb[BTH_OFF + 0] = desc.opcode;
    hb[BTH_OFF + 1] = {2'b00, pad_cnt, 4'h0};
    hb[BTH_OFF + 2] = PKEY[15:8];
    hb[BTH_OFF + 3] = PKEY[7:0];
    hb[BTH_OFF + 4] = 8'h00;
    hb[BTH_OFF + 8] = 8'h00;
    for (int k = 0; k < 3; k++) begin
      hb[BTH_OFF + 5 + k] = desc.dest_qp[8*(2-k) +: 8];
      hb[BTH_OFF + 9 + k] = desc.psn[8*(2-k) +: 8];
    end
    for (int k = 0; k < 8; k++) hb[RETH_OFF + k] = desc.vaddr[8*(7-k) +: 8];
    for (int k = 0; k < 4; k++) begin
      hb[RETH_OFF + 8 + k]  = desc.rkey[8*(3-k) +: 8];
      hb[RETH_OFF + 12 + k] = desc.dma_len[8*(3-k) +: 8];
    end
  end

  for (genvar g = 0; g < HDR_MAX; g++) begin : g_pack
    assign hdr_vec[g*8 +: 8] = hb[g];
  end
endmodule

// File: rtl/rv2_icrc.sv
`timescale 1ns/1ps
module rv2_icrc
  import rv2_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_out
);
  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) crc_q <= 32'hFFFF_FFFF;
    else if (en)         crc_q <= crc32_byte(crc_q, din);
  end

  assign crc_out = ~crc_q;

  // R7: the running CRC only moves on an enabled byte
  assert_crc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !en) |=> $stable(crc_q));
endmodule

// File: rtl/rv2_framer.sv
`timescale 1ns/1ps
module rv2_framer
  import rv2_pkg::*;
#(
  parameter logic [15:0] SRC_PORT = 16'hC000,
  parameter logic [15:0] PKEY     = 16'hFFFF,
  parameter logic [7:0]  TTL      = 8'd64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [47:0]       dst_mac,
  input  logic [47:0]       src_mac,
  input  logic [31:0]       src_ip,
  input  logic [31:0]       dst_ip,
  input  logic [7:0]        opcode,
  input  logic [23:0]       dest_qp,
  input  logic [23:0]       psn,
  input  logic [63:0]       vaddr,
  input  logic [31:0]       rkey,
  input  logic [31:0]       dma_len,
  input  logic [PLEN_W-1:0] pay_len,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [7:0]        s_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [7:0]        m_tdata,
  output logic              m_tlast
);
  rv2_state_e             st;
  logic [PLEN_W-1:0]      idx;
  rv2_desc_t              desc_q;
  logic [HDR_MAX*8-1:0]   hdr_vec;
  logic [6:0]             hdr_len;
  logic [1:0]             pad_cnt;
  logic [31:0]            crc_fin;
  logic                   fire, crc_en, crc_clr;
  logic [7:0]             crc_din;
  logic [PLEN_W-1:0]      hdr_last, pay_last, pad_last;

  rv2_hdr_build #(.SRC_PORT(SRC_PORT), .PKEY(PKEY), .TTL(TTL)) u_hdr (
    .desc(desc_q), .hdr_vec(hdr_vec), .hdr_len(hdr_len), .pad_cnt(pad_cnt));

  rv2_icrc u_crc (
    .clk(clk), .rst_n(rst_n), .clear(crc_clr), .en(crc_en), .din(crc_din), .crc_out(crc_fin));

  assign hdr_ready = (st == ST_IDLE);
  assign hdr_last  = {{(PLEN_W-7){1'b0}}, hdr_len} - 1'b1;
  assign pay_last  = desc_q.pay_len - 1'b1;
  assign pad_last  = {{(PLEN_W-2){1'b0}}, pad_cnt} - 1'b1;

  always_comb begin
    m_tvalid = 1'b0;
    m_tdata  = 8'h00;
    m_tlast  = 1'b0;
    s_tready = 1'b0;
    case (st)
      ST_HDR: begin
        m_tvalid = 1'b1;
        m_tdata  = hdr_vec[idx[6:0]*8 +: 8];
      end
      ST_PAY: begin
        m_tvalid = s_tvalid;
        m_tdata  = s_tdata;
        s_tready = m_tready;
      end
      ST_PAD: m_tvalid = 1'b1;
      ST_TRL: begin
        m_tvalid = 1'b1;
        m_tdata  = crc_fin[idx[1:0]*8 +: 8];
        m_tlast  = (idx[1:0] == 2'd3);
      end
      default: ;
    endcase
  end

  assign fire    = m_tvalid && m_tready;
  assign crc_clr = (st == ST_IDLE);
  // the last eight Ethernet bytes stand in for the all-ones prefix
  assign crc_en  = fire && (st != ST_TRL) &&
                   !(st == ST_HDR && idx < PLEN_W'(ETH_BYTES - PREFIX_ONES));
  assign crc_din = (st == ST_HDR && (idx < PLEN_W'(ETH_BYTES) || icrc_mask(idx[6:0])))
                   ? 8'hFF : m_tdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      idx    <= '0;
      desc_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (hdr_valid) begin
          desc_q <= '{dst_mac: dst_mac, src_mac: src_mac, src_ip: src_ip, dst_ip: dst_ip,
                      opcode: opcode, dest_qp: dest_qp, psn: psn, vaddr: vaddr,
                      rkey: rkey, dma_len: dma_len, pay_len: pay_len};
          st  <= ST_HDR;
          idx <= '0;
        end
        ST_HDR: if (fire) begin
          if (idx == hdr_last) begin
            idx <= '0;
            if (desc_q.pay_len != '0) st <= ST_PAY;
            else if (pad_cnt != 2'd0) st <= ST_PAD;
            else                      st <= ST_TRL;
          end else idx <= idx + 1'b1;
        end
        ST_PAY: if (fire) begin
          if (idx == pay_last) begin
            idx <= '0;
            st  <= (pad_cnt != 2'd0) ? ST_PAD : ST_TRL;
          end else idx <= idx + 1'b1;
        end
        ST_PAD: if (fire) begin
          if (idx == pad_last) begin
            idx <= '0;
            st  <= ST_TRL;
          end else idx <= idx + 1'b1;
        end
        ST_TRL: if (fire) begin
          if (idx[1:0] == 2'd3) begin
            idx <= '0;
            st  <= ST_IDLE;
          end else idx <= idx + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // byte count of the packet in flight, kept for the length check below
  logic [PLEN_W-1:0] sent_cnt, pkt_total;
  assign pkt_total = {{(PLEN_W-7){1'b0}}, hdr_len} + desc_q.pay_len
                   + {{(PLEN_W-2){1'b0}}, pad_cnt} + PLEN_W'(ICRC_BYTES);
  always_ff @(posedge clk) begin
    if (!rst_n || st == ST_IDLE) sent_cnt <= '0;
    else if (fire)               sent_cnt <= sent_cnt + 1'b1;
  end

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready && st != ST_PAY) |=> (m_tvalid && $stable(m_tdata)));

  assert_one_packet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready) |=> !hdr_ready);

  assert_pass_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready) |-> (m_tvalid && m_tready && m_tdata == s_tdata));

  assert_pkt_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && m_tlast) |-> (sent_cnt + 1'b1 == pkt_total));
endmodule

// File: tb/tb_rv2_framer.sv
`timescale 1ns/1ps
module tb_rv2_framer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, hdr_valid, hdr_ready;
  logic [47:0] dst_mac, src_mac;
  logic [31:0] src_ip, dst_ip, rkey, dma_len;
  logic [7:0]  opcode;
  logic [23:0] dest_qp, psn;
  logic [63:0] vaddr;
  logic [15:0] pay_len;
  logic        s_tvalid, s_tready, m_tvalid, m_tready, m_tlast;
  logic [7:0]  s_tdata, m_tdata;

  rv2_framer dut (.*);

  int total = 0, bad = 0;
  logic [7:0]  exp_q[$];
  logic [7:0]  pay[$];
  int          hl, plen, padn;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] b);
    for (int k = 0; k < 8; k++) begin
      if ((c[0] ^ b[k]) == 1'b1) c = (c >> 1) ^ 32'hEDB88320;
      else c = c >> 1;
    end
    return c;
  endfunction

  function automatic string tag_of(int i);
    if (i < 14) return "R1";
    if (i == 16 || i == 17 || i == 38 || i == 39) return "R5";
    if (i == 24 || i == 25) return "R6";
    if (i >= 34 && i < 42) return "R2";
    if (i < 42) return "R1";
    if (i == 43) return "R4";
    if (i < 54) return "R1";
    if (i < hl) return "R3";
    if (i < hl + plen) return "R9";
    if (i < hl + plen + padn) return "R4";
    return "R7";
  endfunction

  task automatic putn(logic [63:0] v, int n);
    for (int k = n - 1; k >= 0; k--) exp_q.push_back(v[8*k +: 8]);
  endtask

  task automatic build(logic [7:0] op, int len, int seed);
    bit reth;
    int udp_l, sum;
    logic [31:0] c;
    reth = (op[4:0] == 5'h06 || op[4:0] == 5'h0A || op[4:0] == 5'h0C);
    plen = len;
    padn = (4 - (len % 4)) % 4;
    hl   = reth ? 70 : 54;
    dst_mac = 48'h0200_0000_0000 + 48'(seed * 17);
    src_mac = 48'h0600_1122_3300 + 48'(seed);
    src_ip  = 32'h0A00_0001 + 32'(seed * 3);
    dst_ip  = 32'hC0A8_0100 + 32'(seed * 5);
    opcode  = op;
    dest_qp = 24'h00_1234 + 24'(seed);
    psn     = 24'hFF_FFF0 + 24'(seed);
    vaddr   = 64'h0000_7F00_DEAD_0000 + 64'(seed);
    rkey    = 32'h1357_9BDF ^ 32'(seed);
    dma_len = 32'(len * 3);
    pay_len = 16'(len);
    pay.delete();
    for (int i = 0; i < len; i++) pay.push_back(8'((i * 7 + seed * 13) & 8'hFF));
    exp_q.delete();
    udp_l = 8 + 12 + (reth ? 16 : 0) + len + padn + 4;
    putn(dst_mac, 6); putn(src_mac, 6); putn(16'h0800, 2);
    putn(16'h4500, 2); putn(16'(udp_l + 20), 2); putn(16'h0000, 2); putn(16'h4000, 2);
    putn(8'd64, 1); putn(8'd17, 1); putn(16'h0000, 2); putn(src_ip, 4); putn(dst_ip, 4);
    putn(16'hC000, 2); putn(16'd4791, 2); putn(16'(udp_l), 2); putn(16'h0000, 2);
    putn(op, 1); putn({2'b00, 2'(padn), 4'h0}, 1); putn(16'hFFFF, 2); putn(8'h00, 1);
    putn(dest_qp, 3); putn(8'h00, 1); putn(psn, 3);
    if (reth) begin putn(vaddr, 8); putn(rkey, 4); putn(dma_len, 4); end
    sum = 0;
    for (int i = 0; i < 10; i++) sum += {exp_q[14 + 2*i], exp_q[15 + 2*i]};
    while (sum > 16'hFFFF) sum = (sum & 16'hFFFF) + (sum >> 16);
    exp_q[24] = 8'(~sum >> 8);
    exp_q[25] = 8'(~sum);
    for (int i = 0; i < len; i++) exp_q.push_back(pay[i]);
    for (int i = 0; i < padn; i++) exp_q.push_back(8'h00);
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 8; i++) c = crc_step(c, 8'hFF);
    for (int i = 14; i < exp_q.size(); i++)
      if (i == 15 || i == 22 || i == 24 || i == 25 || i == 40 || i == 41 || i == 46)
        c = crc_step(c, 8'hFF);
      else c = crc_step(c, exp_q[i]);
    c = ~c;
    putn({c[7:0], c[15:8], c[23:16], c[31:24]}, 4);
  endtask

  task automatic run_pkt(logic [7:0] op, int len, int seed, bit stall);
    int oi = 0, pi = 0, cyc = 0, n;
    bit acc_pend = 0, acc_done = 0, pv = 0, pr = 0;
    logic [7:0] pd = 0;
    int poi = 0;
    build(op, len, seed);
    n = exp_q.size();
    @(negedge clk);
    hdr_valid = 1'b1;
    forever begin
      if (cyc > 0) @(negedge clk);
      cyc++;
      if (acc_pend) begin hdr_valid = 1'b0; acc_done = 1; acc_pend = 0; end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      m_tready = stall ? lf[0] | lf[3] : 1'b1;
      s_tvalid = (pi < plen) && (stall ? (lf[5] | lf[8]) : 1'b1);
      s_tdata  = (pi < plen) ? pay[pi] : 8'h00;
      #1;
      if (hdr_valid && hdr_ready) acc_pend = 1;
      if (acc_done) chk(!hdr_ready, "R10", "hdr_ready while busy", hdr_ready, 0);
      if (pv && !pr && !(poi >= hl && poi < hl + plen))
        chk(m_tvalid && m_tdata == pd, "R8", $sformatf("held byte %0d", poi), m_tdata, pd);
      if (acc_done && oi >= hl && oi < hl + plen)
        chk(s_tready == m_tready, "R9", "s_tready in payload", s_tready, m_tready);
      else
        chk(!s_tready, "R9", "s_tready outside payload", s_tready, 0);
      pv = m_tvalid; pr = m_tready; pd = m_tdata; poi = oi;
      if (s_tvalid && s_tready) pi++;
      if (m_tvalid && m_tready) begin
        chk(m_tdata == exp_q[oi], tag_of(oi), $sformatf("byte %0d op %0h", oi, op), m_tdata, exp_q[oi]);
        chk(m_tlast == (oi == n - 1), "R11", $sformatf("tlast at %0d", oi), m_tlast, oi == n - 1);
        oi++;
        if (m_tlast) chk(oi == len + padn + hl + 4, "R11", "packet length", oi, len + padn + hl + 4);
      end
      if (oi >= n) break;
      if (cyc > 40000) begin
        chk(0, "R11", "packet did not finish", oi, n);
        break;
      end
    end
  endtask

  initial begin
    rst_n = 0; hdr_valid = 0; s_tvalid = 0; s_tdata = 0; m_tready = 1;
    dst_mac = 0; src_mac = 0; src_ip = 0; dst_ip = 0; opcode = 0; dest_qp = 0;
    psn = 0; vaddr = 0; rkey = 0; dma_len = 0; pay_len = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!m_tvalid && !s_tready && hdr_ready, "R12", "reset outputs",
        {m_tvalid, s_tready, hdr_ready}, 3'b001);
    @(negedge clk);
    rst_n = 1;
    run_pkt(8'h04, 8, 1, 0);      // no extension, pad 0
    run_pkt(8'h0A, 13, 2, 1);     // extension, pad 3, stalls
    run_pkt(8'h0C, 0, 3, 1);      // extension, empty payload
    run_pkt(8'h64, 6, 4, 1);      // low bits 0x04: no extension, pad 2
    run_pkt(8'h2A, 1, 5, 0);      // low bits 0x0A: extension, pad 3
    run_pkt(8'h06, 2049, 6, 1);   // long payload, pad 3
    run_pkt(8'h00, 7, 7, 1);      // pad 1
    @(negedge clk); #1;
    chk(hdr_ready && !m_tvalid, "R10", "idle after last packet", {hdr_ready, m_tvalid}, 2'b10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired R11 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule